// File: doc/BRIEF.md
# Vector Compare-to-Mask Write Sequencer

This block carries out one vector integer compare and records the boolean outcome of each element into a destination mask register. It handles one element per clock. On each cycle it fetches element operands through simple combinational read ports. It compares them at the selected element width and merges the result into a 64-bit mask word through a read-modify-write port. It honours the v0 predicate, the start index and the active length. When asked, it then clears the unused tail slots. A start pulse launches the operation and a one-cycle done pulse ends it.

Each element owns a slot of `cfg_mlen` bits. Only the lowest bit of a slot carries meaning. The slot for element i starts at bit offset mlen*i, which falls in word (mlen*i)/64 at bit (mlen*i) mod 64. The block captures the configuration when it accepts start. The surrounding logic keeps the configuration ports steady until done.

Top module: `vcmp_mask_seq`

## Requirements
- R1: Element i's slot is located in mask word (cfg_mlen*i)/64 at bit position (cfg_mlen*i) mod 64. cfg_mlen is a power of two from 1 to 64. The same word index selects the v0 word and the destination word.
- R2: A result write clears all cfg_mlen bits of the slot and puts the compare result in the slot's lowest bit. Every bit of the word outside the slot keeps its value read on mask_rdata.
- R3: When cfg_vm is 0, element i is processed only if v0_word holds a 1 at the slot's lowest bit position. Otherwise the block does not write that slot. When cfg_vm is 1, every element in range is processed.
- R4: The block processes elements in increasing order from cfg_vstart up to cfg_vl-1, one per cycle. On a legal operation, vstart_clr pulses together with done to tell the owner to reset the start index to 0.
- R5: When cfg_tail_zero is 1 and cfg_vl is nonzero, the block clears the slots for indices cfg_vl through cfg_vlmax-1 after the active elements. When cfg_tail_zero is 0 or cfg_vl is 0, no tail slot is written.
- R6: The operation is illegal if cfg_vill is 1, if cfg_sew is not 8, 16, 32 or 64, or if cfg_src is 3. An illegal operation writes nothing, and illegal is high during its done cycle. In that case vstart_clr stays low.
- R7: The second operand depends on cfg_src. Code 0 selects vs1_elem, code 1 selects scalar_op and code 2 selects imm5. Operands are truncated to SEW. The immediate is sign-extended for opcodes 0, 1, 3, 5 and 7, and zero-extended for opcodes 2, 4 and 6.
- R8: cfg_op selects the relation between the vs2 element and the second operand, both taken at SEW width. The codes are 0 eq, 1 ne, 2 lt unsigned, 3 lt signed, 4 le unsigned, 5 le signed, 6 gt unsigned and 7 gt signed.
- R9: done is a single-cycle pulse. When start is sampled, done follows after (active elements + tail slots + 1) cycles. With cfg_vl equal to 0, or on an illegal operation, this is one cycle, with no writes. done, illegal and mask_we are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| cfg_vill | input | 1 | Illegal-configuration flag |
| cfg_sew | input | 7 | Element width in bits |
| cfg_mlen | input | 7 | Mask slot width in bits |
| cfg_vl | input | IDX_W | Active vector length |
| cfg_vlmax | input | IDX_W | Number of slots in the destination |
| cfg_vstart | input | IDX_W | First element index |
| cfg_vm | input | 1 | 1: unmasked, 0: predicate on v0 |
| cfg_tail_zero | input | 1 | Clear tail slots |
| cfg_op | input | 3 | Compare opcode |
| cfg_src | input | 2 | Second-operand source |
| scalar_op | input | 64 | Scalar operand |
| imm5 | input | 5 | Immediate operand |
| elem_idx | output | IDX_W | Element index being read |
| vs2_elem | input | 64 | vs2 element at elem_idx (low SEW bits used) |
| vs1_elem | input | 64 | vs1 element at elem_idx (low SEW bits used) |
| mask_word_idx | output | IDX_W+1 | Mask word index for v0 and destination |
| v0_word | input | 64 | v0 word at mask_word_idx |
| mask_rdata | input | 64 | Destination word at mask_word_idx |
| mask_we | output | 1 | Destination word write enable |
| mask_wdata | output | 64 | Merged destination word |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Operation rejected (valid with done) |
| vstart_clr | output | 1 | Request to reset the start index |

## Verification
The hardest situation to reach is a slot that shares its word with many neighbours. In that case one stale bit, or a merge that spills out of its slot, corrupts an element that was written earlier or later. Two further hard cases are a start index at or beyond the length while a tail still needs clearing, and a masked-off element in the middle of a run. The stimulus sweeps every opcode, source and element width. For each operation it steps through slot widths from 1 to 64 together with mixed lengths, start offsets, predicate settings and tail settings. The operand pools are seeded with scalar, immediate and vs1 values, so that equality and boundary orderings occur often. The bench loads pseudo-random destination words and compares every word against an arithmetic model.

// File: rtl/vcmp_pkg.sv
// Shared encodings for the compare-to-mask sequencer.
// Assumes 64-bit mask words and elements up to 64 bits.
package vcmp_pkg;
    localparam int WORD_W = 64;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int MLEN_W = POS_W + 1;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_LTU = 3'd2,
        CMP_LT  = 3'd3,
        CMP_LEU = 3'd4,
        CMP_LE  = 3'd5,
        CMP_GTU = 3'd6,
        CMP_GT  = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        SRC_VEC = 2'd0,
        SRC_SCL = 2'd1,
        SRC_IMM = 2'd2,
        SRC_BAD = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_TAIL = 2'd2,
        ST_FIN  = 2'd3
    } seq_st_e;

    // True for the element widths the block accepts
    function automatic logic sew_legal(input logic [6:0] sew);
        return (sew == 7'd8) || (sew == 7'd16) || (sew == 7'd32) || (sew == 7'd64);
    endfunction
endpackage

// File: rtl/vcmp_elem_cmp.sv
// Element compare: selects the second operand, extends both operands
// at SEW width by the signedness of the opcode, and evaluates the relation.
// Assumes sew is one of 8/16/32/64 whenever the result is used.
module vcmp_elem_cmp
    import vcmp_pkg::*;
(
    input  logic [6:0]  sew,
    input  logic [2:0]  op,
    input  logic [1:0]  src,
    input  logic [63:0] vs2,
    input  logic [63:0] vs1,
    input  logic [63:0] scalar,
    input  logic [4:0]  imm,
    output logic        hit
);
    cmp_op_e     opc;
    src_sel_e    sel;
    logic        uns;
    logic [63:0] b_raw;
    logic [64:0] a_x, b_x;
    logic        lt, eq;

    assign opc = cmp_op_e'(op);
    assign sel = src_sel_e'(src);
    assign uns = (opc == CMP_LTU) || (opc == CMP_LEU) || (opc == CMP_GTU);

    // Extend the low SEW bits to 65 bits, signed or unsigned
    function automatic logic [64:0] widen(input logic [63:0] x, input logic [6:0] w,
                                          input logic sgn);
        case (w)
            7'd8:    widen = {{57{sgn & x[7]}},  x[7:0]};
            7'd16:   widen = {{49{sgn & x[15]}}, x[15:0]};
            7'd32:   widen = {{33{sgn & x[31]}}, x[31:0]};
            default: widen = {sgn & x[63], x};
        endcase
    endfunction

    // Pick the second operand, extending the immediate per signedness
    always_comb begin
        case (sel)
            SRC_VEC: b_raw = vs1;
            SRC_SCL: b_raw = scalar;
            default: b_raw = uns ? {59'd0, imm} : {{59{imm[4]}}, imm};
        endcase
    end

    assign a_x = widen(vs2, sew, !uns);
    assign b_x = widen(b_raw, sew, !uns);
    assign lt  = $signed(a_x) < $signed(b_x);
    assign eq  = (a_x == b_x);

    // Evaluate the selected relation
    always_comb begin
        case (opc)
            CMP_EQ:           hit = eq;
            CMP_NE:           hit = !eq;
            CMP_LTU, CMP_LT:  hit = lt;
            CMP_LEU, CMP_LE:  hit = lt | eq;
            default:          hit = !(lt | eq);
        endcase
    end
endmodule

// File: rtl/vcmp_slot_merge.sv
// Slot merge: clears an mlen-bit slot at bit pos of a word and places
// one result bit at the slot's lowest position.
// Assumes pos + mlen <= WORD_W (power-of-two slot widths).
module vcmp_slot_merge
    import vcmp_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [POS_W-1:0]  pos,
    input  logic [MLEN_W-1:0] mlen,
    input  logic              bit_in,
    output logic [WORD_W-1:0] new_word
);
    logic [WORD_W:0]   ones;
    logic [WORD_W-1:0] slot;

    assign ones     = ({{WORD_W{1'b0}}, 1'b1} << mlen) - {{WORD_W{1'b0}}, 1'b1};
    assign slot     = ones[WORD_W-1:0] << pos;
    assign new_word = (old_word & ~slot) | ({{(WORD_W-1){1'b0}}, bit_in} << pos);
endmodule

// File: rtl/vcmp_seq_ctrl.sv
// Sequencer control: walks active indices vstart..vl-1, then tail indices
// vl..vlmax-1 when tail clearing applies, then a one-cycle finish state.
// Assumes vl <= vlmax; start is honoured only while idle.
module vcmp_seq_ctrl
    import vcmp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_ok,
    input  logic [IDX_W-1:0] vl,
    input  logic [IDX_W-1:0] vlmax,
    input  logic [IDX_W-1:0] vstart,
    input  logic             tail_zero,
    output logic [IDX_W-1:0] idx,
    output logic             idle,
    output logic             in_act,
    output logic             in_tail,
    output logic             done,
    output logic             err
);
    localparam int CW = IDX_W + 1;

    seq_st_e          st;
    logic [IDX_W-1:0] vl_q, vlmax_q;
    logic             tz_q;
    logic [CW-1:0]    nxt;
    logic             start_tail;

    assign nxt        = {1'b0, idx} + CW'(1);
    assign start_tail = tail_zero && (vl != '0) && (vl < vlmax);

    // State, index and latched bounds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            vl_q    <= '0;
            vlmax_q <= '0;
            tz_q    <= 1'b0;
            err     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    vl_q    <= vl;
                    vlmax_q <= vlmax;
                    tz_q    <= tail_zero;
                    err     <= !cfg_ok;
                    if (!cfg_ok || vl == '0) begin
                        st <= ST_FIN;
                    end else if (vstart >= vl) begin
                        if (start_tail) begin
                            st  <= ST_TAIL;
                            idx <= vl;
                        end else begin
                            st <= ST_FIN;
                        end
                    end else begin
                        st  <= ST_ACT;
                        idx <= vstart;
                    end
                end
                ST_ACT: begin
                    if (nxt == {1'b0, vl_q}) begin
                        if (tz_q && (vl_q < vlmax_q)) begin
                            st  <= ST_TAIL;
                            idx <= vl_q;
                        end else begin
                            st <= ST_FIN;
                        end
                    end else begin
                        idx <= nxt[IDX_W-1:0];
                    end
                end
                ST_TAIL: begin
                    if (nxt == {1'b0, vlmax_q}) st <= ST_FIN;
                    else                        idx <= nxt[IDX_W-1:0];
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (st == ST_IDLE);
    assign in_act  = (st == ST_ACT);
    assign in_tail = (st == ST_TAIL);
    assign done    = (st == ST_FIN);
endmodule

// File: rtl/vcmp_mask_seq.sv
// Compare-to-mask write sequencer top. Captures the operation on start,
// drives element and mask-word indices, merges each result (or a tail
// clear) into the addressed mask word, and reports done/illegal.
// Assumes combinational read ports and that cfg_* stay steady until done.
module vcmp_mask_seq
    import vcmp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_vill,
    input  logic [6:0]       cfg_sew,
    input  logic [6:0]       cfg_mlen,
    input  logic [IDX_W-1:0] cfg_vl,
    input  logic [IDX_W-1:0] cfg_vlmax,
    input  logic [IDX_W-1:0] cfg_vstart,
    input  logic             cfg_vm,
    input  logic             cfg_tail_zero,
    input  logic [2:0]       cfg_op,
    input  logic [1:0]       cfg_src,
    input  logic [63:0]      scalar_op,
    input  logic [4:0]       imm5,
    output logic [IDX_W-1:0] elem_idx,
    input  logic [63:0]      vs2_elem,
    input  logic [63:0]      vs1_elem,
    output logic [IDX_W:0]   mask_word_idx,
    input  logic [63:0]      v0_word,
    input  logic [63:0]      mask_rdata,
    output logic             mask_we,
    output logic [63:0]      mask_wdata,
    output logic             done,
    output logic             illegal,
    output logic             vstart_clr
);
    localparam int OFF_W = IDX_W + MLEN_W;

    logic [6:0]        sew_q;
    logic [MLEN_W-1:0] mlen_q;
    logic              vm_q;
    logic [2:0]        op_q;
    logic [1:0]        src_q;
    logic [63:0]       scalar_q;
    logic [4:0]        imm_q;

    logic              cfg_ok, idle, in_act, in_tail, err;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    logic [POS_W-1:0]  pos;
    logic              hit, active;

    assign cfg_ok = !cfg_vill && sew_legal(cfg_sew) && (src_sel_e'(cfg_src) != SRC_BAD);

    // Capture the operation's parameters when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sew_q    <= 7'd8;
            mlen_q   <= MLEN_W'(1);
            vm_q     <= 1'b1;
            op_q     <= '0;
            src_q    <= '0;
            scalar_q <= '0;
            imm_q    <= '0;
        end else if (start && idle) begin
            sew_q    <= cfg_sew;
            mlen_q   <= cfg_mlen[MLEN_W-1:0];
            vm_q     <= cfg_vm;
            op_q     <= cfg_op;
            src_q    <= cfg_src;
            scalar_q <= scalar_op;
            imm_q    <= imm5;
        end
    end

    vcmp_seq_ctrl #(.IDX_W(IDX_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_ok    (cfg_ok),
        .vl        (cfg_vl),
        .vlmax     (cfg_vlmax),
        .vstart    (cfg_vstart),
        .tail_zero (cfg_tail_zero),
        .idx       (idx),
        .idle      (idle),
        .in_act    (in_act),
        .in_tail   (in_tail),
        .done      (done),
        .err       (err)
    );

    vcmp_elem_cmp cmp_i (
        .sew    (sew_q),
        .op     (op_q),
        .src    (src_q),
        .vs2    (vs2_elem),
        .vs1    (vs1_elem),
        .scalar (scalar_q),
        .imm    (imm_q),
        .hit    (hit)
    );

    assign off           = {{IDX_W{1'b0}}, mlen_q} * {{MLEN_W{1'b0}}, idx};
    assign pos           = off[POS_W-1:0];
    assign mask_word_idx = off[OFF_W-1:POS_W];
    assign elem_idx      = idx;
    assign active        = vm_q | v0_word[pos];
    assign mask_we       = (in_act & active) | in_tail;

    vcmp_slot_merge merge_i (
        .old_word (mask_rdata),
        .pos      (pos),
        .mlen     (mlen_q),
        .bit_in   (in_act & hit),
        .new_word (mask_wdata)
    );

    assign illegal    = done & err;
    assign vstart_clr = done & ~err;
endmodule

// File: rtl/vcmp_mask_seq_chk.sv
// Property checker for the compare-to-mask sequencer, bound to its top.
// Assumes configuration ports are held steady while an operation runs.
module vcmp_mask_seq_chk
    import vcmp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [6:0]       cfg_mlen,
    input logic [IDX_W-1:0] cfg_vl,
    input logic [IDX_W-1:0] cfg_vlmax,
    input logic             cfg_vm,
    input logic [IDX_W-1:0] elem_idx,
    input logic [63:0]      v0_word,
    input logic [63:0]      mask_rdata,
    input logic             mask_we,
    input logic [63:0]      mask_wdata,
    input logic             done,
    input logic             illegal,
    input logic             vstart_clr
);
    localparam int OFF_W = IDX_W + 7;

    logic [OFF_W-1:0] c_off;
    logic [5:0]       c_pos;
    logic [64:0]      c_ones;
    logic [63:0]      c_slot, c_low;
    logic             busy;

    assign c_off  = {{IDX_W{1'b0}}, cfg_mlen} * {7'd0, elem_idx};
    assign c_pos  = c_off[5:0];
    assign c_ones = (65'd1 << cfg_mlen) - 65'd1;
    assign c_slot = c_ones[63:0] << c_pos;
    assign c_low  = 64'd1 << c_pos;

    // Track whether an operation is in flight, seen from the ports
    always_ff @(posedge clk) begin
        if (!rst_n)               busy <= 1'b0;
        else if (done)            busy <= 1'b0;
        else if (start && !busy)  busy <= 1'b1;
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_vl_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && cfg_vl == '0) |=> done);
    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !vstart_clr && !mask_we));
    a_r2_slot_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> ((mask_wdata & c_slot & ~c_low) == 64'd0));
    a_r2_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> ((mask_wdata & ~c_slot) == (mask_rdata & ~c_slot)));
    a_r3_masked_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !cfg_vm && elem_idx < cfg_vl) |-> v0_word[c_pos]);
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |-> (elem_idx < cfg_vlmax));
endmodule

bind vcmp_mask_seq vcmp_mask_seq_chk #(.IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_mlen   (cfg_mlen),
    .cfg_vl     (cfg_vl),
    .cfg_vlmax  (cfg_vlmax),
    .cfg_vm     (cfg_vm),
    .elem_idx   (elem_idx),
    .v0_word    (v0_word),
    .mask_rdata (mask_rdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .done       (done),
    .illegal    (illegal),
    .vstart_clr (vstart_clr)
);

// File: tb/vcmp_mask_seq_tb_top.sv
`timescale 1ns/1ps
module vcmp_mask_seq_tb_top;
    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             cfg_vill = 1'b0;
    logic [6:0]       cfg_sew = 7'd8;
    logic [6:0]       cfg_mlen = 7'd1;
    logic [IDX_W-1:0] cfg_vl = '0, cfg_vlmax = '0, cfg_vstart = '0;
    logic             cfg_vm = 1'b1, cfg_tail_zero = 1'b0;
    logic [2:0]       cfg_op = '0;
    logic [1:0]       cfg_src = '0;
    logic [63:0]      scalar_op = '0;
    logic [4:0]       imm5 = '0;
    logic [IDX_W-1:0] elem_idx;
    logic [63:0]      vs2_elem, vs1_elem, v0_word, mask_rdata, mask_wdata;
    logic [IDX_W:0]   mask_word_idx;
    logic             mask_we, done, illegal, vstart_clr;

    logic [63:0] vs2_mem [0:255];
    logic [63:0] vs1_mem [0:255];
    logic [63:0] v0_mem  [0:511];
    logic [63:0] dmem    [0:511];
    logic [63:0] exp_mem [0:511];
    logic        load_req = 1'b0;
    logic [31:0] seed = 32'd1;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vcmp_mask_seq #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_vill(cfg_vill),
        .cfg_sew(cfg_sew), .cfg_mlen(cfg_mlen), .cfg_vl(cfg_vl),
        .cfg_vlmax(cfg_vlmax), .cfg_vstart(cfg_vstart), .cfg_vm(cfg_vm),
        .cfg_tail_zero(cfg_tail_zero), .cfg_op(cfg_op), .cfg_src(cfg_src),
        .scalar_op(scalar_op), .imm5(imm5), .elem_idx(elem_idx),
        .vs2_elem(vs2_elem), .vs1_elem(vs1_elem), .mask_word_idx(mask_word_idx),
        .v0_word(v0_word), .mask_rdata(mask_rdata), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .done(done), .illegal(illegal),
        .vstart_clr(vstart_clr)
    );

    assign vs2_elem   = vs2_mem[elem_idx];
    assign vs1_elem   = vs1_mem[elem_idx];
    assign v0_word    = v0_mem[mask_word_idx];
    assign mask_rdata = dmem[mask_word_idx];

    function automatic logic [63:0] scramble(input logic [31:0] s, input int w);
        logic [63:0] x;
        x = {s, w[31:0]} * 64'h9E37_79B9_7F4A_7C15;
        return x ^ ({32'd0, s} << 17);
    endfunction

    // Destination mask memory: bulk load or write port
    always @(posedge clk) begin
        if (load_req) begin
            for (int w = 0; w < 512; w++) dmem[w] <= scramble(seed, w);
        end else if (mask_we) begin
            dmem[mask_word_idx] <= mask_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic bit ref_cmp(input logic [63:0] a, input logic [63:0] b,
                                   input int sew, input int op);
        int sh;
        longint sa, sb;
        longint unsigned ua, ub;
        sh = 64 - sew;
        ua = (a << sh) >> sh;
        ub = (b << sh) >> sh;
        sa = longint'(a << sh) >>> sh;
        sb = longint'(b << sh) >>> sh;
        case (op)
            0: return ua == ub;
            1: return ua != ub;
            2: return ua < ub;
            3: return sa < sb;
            4: return ua <= ub;
            5: return sa <= sb;
            6: return ua > ub;
            default: return sa > sb;
        endcase
    endfunction

    task automatic put_slot(input int mlen, input int i, input bit r);
        int off, w, p;
        off = mlen * i;
        w = off / 64;
        p = off % 64;
        for (int b = 0; b < mlen; b++) exp_mem[w][p + b] = 1'b0;
        exp_mem[w][p] = r;
    endtask

    task automatic run_op(input int sew, input int mlen, input int vl, input int vlmax,
                          input int vstart, input bit vm, input bit tze, input int op,
                          input int src, input bit vill);
        bit          exp_ill, ok, r;
        int          exp_cyc, cyc, act_n, tail_n, badw;
        logic [63:0] b, hi, simm, zimm;
        bit          got_ill, got_clr;

        cfg_sew = 7'(sew); cfg_mlen = 7'(mlen); cfg_vl = IDX_W'(vl);
        cfg_vlmax = IDX_W'(vlmax); cfg_vstart = IDX_W'(vstart); cfg_vm = vm;
        cfg_tail_zero = tze; cfg_op = 3'(op); cfg_src = 2'(src); cfg_vill = vill;
        scalar_op = {$urandom, $urandom};
        imm5 = 5'($urandom);
        simm = {{59{imm5[4]}}, imm5};
        zimm = {59'd0, imm5};
        hi = (sew >= 64) ? 64'd0 : ~((64'd1 << sew) - 64'd1);
        for (int i = 0; i < 256; i++) begin
            vs1_mem[i] = {$urandom, $urandom};
            case ($urandom % 5)
                0: vs2_mem[i] = scalar_op;
                1: vs2_mem[i] = simm;
                2: vs2_mem[i] = zimm;
                3: vs2_mem[i] = vs1_mem[i];
                default: vs2_mem[i] = {$urandom, $urandom};
            endcase
            vs2_mem[i] = vs2_mem[i] ^ ({$urandom, $urandom} & hi);
        end
        for (int w = 0; w < 512; w++) v0_mem[w] = {$urandom, $urandom};
        seed = $urandom;
        @(negedge clk); load_req = 1'b1;
        @(negedge clk); load_req = 1'b0;

        // Arithmetic model of the whole destination register
        for (int w = 0; w < 512; w++) exp_mem[w] = scramble(seed, w);
        exp_ill = vill || !(sew == 8 || sew == 16 || sew == 32 || sew == 64) || src == 3;
        act_n = 0;
        tail_n = 0;
        if (!exp_ill && vl != 0) begin
            for (int i = vstart; i < vl; i++) begin
                act_n++;
                if (!vm && !v0_mem[(mlen * i) / 64][(mlen * i) % 64]) continue;
                case (src)
                    0: b = vs1_mem[i];
                    1: b = scalar_op;
                    default: b = (op == 2 || op == 4 || op == 6) ? zimm : simm;
                endcase
                r = ref_cmp(vs2_mem[i], b, sew, op);
                put_slot(mlen, i, r);
            end
            if (tze) begin
                for (int i = vl; i < vlmax; i++) begin
                    tail_n++;
                    put_slot(mlen, i, 1'b0);
                end
            end
        end
        exp_cyc = act_n + tail_n + 1;

        start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        got_ill = illegal;
        got_clr = vstart_clr;
        chk(cyc == exp_cyc, "R9", "cycles to done (R4 one element per cycle)",
            longint'(cyc), longint'(exp_cyc));
        chk(got_ill == exp_ill, "R6", "illegal flag", got_ill, exp_ill);
        chk(got_clr == !exp_ill, "R4", "vstart_clr with done", got_clr, !exp_ill);
        @(negedge clk);
        chk(!done, "R9", "done single pulse", done, 0);
        ok = 1'b1;
        badw = 0;
        for (int w = 511; w >= 0; w--) if (dmem[w] !== exp_mem[w]) begin ok = 1'b0; badw = w; end
        chk(ok, "R1 R2 R3 R5 R7 R8", $sformatf("mask word %0d", badw),
            dmem[badw], exp_mem[badw]);
    endtask

    task automatic run_all();
        int sews[4] = '{8, 16, 32, 64};
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mask_we && !illegal, "R9", "reset outputs quiet",
            {done, mask_we, illegal}, 0);
        // Sweep width x opcode x source with varied geometry
        for (int s = 0; s < 4; s++)
            for (int op = 0; op < 8; op++)
                for (int src = 0; src < 3; src++) begin
                    k = s * 24 + op * 3 + src;
                    run_op(sews[s], 1 << (k % 7), (k * 5) % 17, 16, (k / 7) % 5,
                           ((k / 2) % 3) != 0, ((k / 3) % 2) == 1, op, src, 1'b0);
                end
        // Boundary cases
        run_op(8, 64, 16, 16, 0, 1'b1, 1'b1, 3, 0, 1'b0);  // R1 full length, wide slots
        run_op(16, 1, 0, 16, 0, 1'b1, 1'b1, 0, 0, 1'b0);   // R5 vl zero: no tail clear
        run_op(32, 4, 3, 16, 7, 1'b1, 1'b1, 1, 1, 1'b0);   // R4 vstart past vl, tail only
        run_op(32, 4, 10, 16, 2, 1'b1, 1'b0, 5, 2, 1'b0);  // R5 tail disabled
        run_op(64, 8, 12, 16, 0, 1'b0, 1'b1, 6, 2, 1'b0);  // R3 masked, R7 zero-extended imm
        run_op(8, 2, 100, 200, 0, 1'b1, 1'b1, 2, 1, 1'b0); // R1 many slots per word
        run_op(12, 1, 8, 16, 0, 1'b1, 1'b1, 0, 0, 1'b0);   // R6 bad width
        run_op(8, 1, 8, 16, 0, 1'b1, 1'b1, 0, 0, 1'b1);    // R6 vill
        run_op(8, 1, 8, 16, 0, 1'b1, 1'b1, 0, 3, 1'b0);    // R6 bad source code
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule